// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block runs one host access to a removable memory or I/O card as a fixed sequence of three timed phases. First comes address setup: the address is valid and no strobe is active. Next the strobe phase drives exactly one of the four command strobes (memory read, memory write, I/O read, I/O write). Last comes hold: the strobe is released, the address stays valid, and write data is still driven. Each phase length is a clock count taken when the request is accepted. A count of zero is raised to one clock, and an I/O write gets one extra setup clock.

When the card wait feature is enabled, the strobe stays active for at least one clock more than its programmed length. It then stays active for as long as the card's wait line, taken through a synchronizer, reports that the card is not ready. A one-cycle done pulse marks the last hold clock. The sequencer returns to idle on the next cycle and only then accepts a new request. Requests that arrive while a transaction is running are dropped.

Top module: `card_strobe_seq`

## Requirements
- R1: While reset is asserted and after its release with no request, all outputs are low.
- R2: A request sampled high in idle starts a transaction on the next cycle, and address valid stays high through setup, strobe and hold.
- R3: The setup phase lasts the setup count in clocks (zero counts as one), with address valid high and all strobes low.
- R4: An I/O write (io=1, wr=1) lengthens setup by exactly one clock over R3.
- R5: The strobe phase lasts the strobe count in clocks (zero counts as one). The strobe is chosen by {io,wr}: 00 memory read, 01 memory write, 10 I/O read, 11 I/O write.
- R6: The hold phase lasts the hold count in clocks (zero counts as one), with strobes low and address valid high.
- R7: Done is high for exactly one cycle, the last hold cycle. On the following cycle address valid is low.
- R8: Data drive is high for every cycle of a write transaction and low throughout a read.
- R9: With wait enabled, the strobe lasts max(L+1, j+2-S) clocks. Here L is the effective strobe count and S the effective setup count. The card wait input is high from before the request and is first seen low at the clock edge j, counting the request edge as 0, so the two-stage synchronizer adds two clocks.
- R10: With wait disabled, the card wait input has no effect on any output.
- R11: A request sampled during a running transaction does not alter it and does not start another one.
- R12: At most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Start request, sampled in idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| setup_cnt_i | input | CNT_W | Setup clocks |
| strobe_cnt_i | input | CNT_W | Minimum strobe clocks |
| hold_cnt_i | input | CNT_W | Hold clocks |
| wait_en_i | input | 1 | Enable strobe extension by card wait |
| card_wait_i | input | 1 | Card wait, high = not ready (asynchronous) |
| addr_vld_o | output | 1 | Address valid |
| mem_oe_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| data_oe_o | output | 1 | Host data drive enable |
| done_o | output | 1 | Last-hold-cycle pulse |

## Verification
A full sweep tries every setup, strobe and hold count from 0 to 3 with all four read/write and memory/I/O kinds. The zero-count sweep points separate the raised-to-one rule from a plain countdown, and the I/O write points isolate the extra setup clock. A second sweep enables wait and releases the card wait line at a range of edges, both earlier and later than the minimum strobe end. This separates the L+1 floor from extension through the synchronizer delay. With wait disabled and the wait line held busy, the timing must be unchanged. Further runs use the largest counts and send an extra request in the middle of a transaction, so that the saturating counter width is exercised and busy requests are shown to be dropped.

// File: rtl/card_strobe_pkg.sv
`timescale 1ns/1ps
package card_strobe_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   // access kind is {io, wr}
   localparam int KIND_NUM = 4;
   typedef logic [1:0] kind_t;

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cs_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cs_phase_ctl.sv
`timescale 1ns/1ps
module cs_phase_ctl
   import card_strobe_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             wr_i,
   input  logic             io_i,
   input  logic [CNT_W-1:0] setup_cnt_i,
   input  logic [CNT_W-1:0] strobe_cnt_i,
   input  logic [CNT_W-1:0] hold_cnt_i,
   input  logic             wait_en_i,
   input  logic             wait_s_i,
   output phase_e           phase_o,
   output kind_t            kind_o,
   output logic             done_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cw
         $error("cs_phase_ctl needs CNT_W >= 1");
      end
   endgenerate

   localparam int NW = CNT_W + 1;
   localparam logic [NW-1:0] ONE = NW'(1);

   phase_e          phase_q;
   kind_t           kind_q;
   logic [NW-1:0]   cnt_q;
   logic [NW-1:0]   len_q;
   logic [NW-1:0]   hold_q;
   logic            wen_q;

   logic [NW-1:0]   s_eff, l_eff, h_eff;
   logic            last;

   always_comb begin
      s_eff = (setup_cnt_i == '0) ? ONE : {1'b0, setup_cnt_i};
      s_eff = s_eff + NW'(io_i & wr_i);
      l_eff = (strobe_cnt_i == '0) ? ONE : {1'b0, strobe_cnt_i};
      l_eff = l_eff + NW'(wait_en_i);
      h_eff = (hold_cnt_i == '0) ? ONE : {1'b0, hold_cnt_i};
   end

   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         hold_q  <= '0;
         wen_q   <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (req_i) begin
                  phase_q <= PH_SETUP;
                  kind_q  <= {io_i, wr_i};
                  cnt_q   <= s_eff - ONE;
                  len_q   <= l_eff;
                  hold_q  <= h_eff;
                  wen_q   <= wait_en_i;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase_q <= PH_STROBE;
                  cnt_q   <= len_q - ONE;
               end else begin
                  cnt_q   <= cnt_q - ONE;
               end
            end
            PH_STROBE: begin
               if (!last) begin
                  cnt_q <= cnt_q - ONE;
               end else if (!(wen_q && wait_s_i)) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= hold_q - ONE;
               end
            end
            PH_HOLD: begin
               if (last) phase_q <= PH_IDLE;
               else      cnt_q   <= cnt_q - ONE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign kind_o  = kind_q;
   assign done_o  = (phase_q == PH_HOLD) && last;
endmodule

// File: rtl/cs_strobe_dec.sv
`timescale 1ns/1ps
module cs_strobe_dec
   import card_strobe_pkg::*;
(
   input  phase_e                phase_i,
   input  kind_t                 kind_i,
   output logic                  addr_vld_o,
   output logic [KIND_NUM-1:0]   stb_o,
   output logic                  data_oe_o
);
   assign addr_vld_o = (phase_i != PH_IDLE);
   assign data_oe_o  = (phase_i != PH_IDLE) && kind_i[0];

   generate
      for (genvar k = 0; k < KIND_NUM; k++) begin : g_stb
         assign stb_o[k] = (phase_i == PH_STROBE) && (kind_i == kind_t'(k));
      end
   endgenerate
endmodule

// File: rtl/card_strobe_seq.sv
`timescale 1ns/1ps
module card_strobe_seq
   import card_strobe_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             wr_i,
   input  logic             io_i,
   input  logic [CNT_W-1:0] setup_cnt_i,
   input  logic [CNT_W-1:0] strobe_cnt_i,
   input  logic [CNT_W-1:0] hold_cnt_i,
   input  logic             wait_en_i,
   input  logic             card_wait_i,
   output logic             addr_vld_o,
   output logic             mem_oe_o,
   output logic             mem_we_o,
   output logic             io_rd_o,
   output logic             io_wr_o,
   output logic             data_oe_o,
   output logic             done_o
);
   phase_e              phase;
   kind_t               kind;
   logic                wait_s;
   logic [KIND_NUM-1:0] stb;

   cs_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (card_wait_i),
      .q_o   (wait_s)
   );

   cs_phase_ctl #(.CNT_W(CNT_W)) ctl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .wr_i         (wr_i),
      .io_i         (io_i),
      .setup_cnt_i  (setup_cnt_i),
      .strobe_cnt_i (strobe_cnt_i),
      .hold_cnt_i   (hold_cnt_i),
      .wait_en_i    (wait_en_i),
      .wait_s_i     (wait_s),
      .phase_o      (phase),
      .kind_o       (kind),
      .done_o       (done_o)
   );

   cs_strobe_dec dec_i (
      .phase_i    (phase),
      .kind_i     (kind),
      .addr_vld_o (addr_vld_o),
      .stb_o      (stb),
      .data_oe_o  (data_oe_o)
   );

   assign mem_oe_o = stb[0];
   assign mem_we_o = stb[1];
   assign io_rd_o  = stb[2];
   assign io_wr_o  = stb[3];
endmodule

// File: rtl/card_strobe_chk.sv
`timescale 1ns/1ps
module card_strobe_chk (
   input logic clk,
   input logic rst_n,
   input logic addr_vld_o,
   input logic mem_oe_o,
   input logic mem_we_o,
   input logic io_rd_o,
   input logic io_wr_o,
   input logic data_oe_o,
   input logic done_o
);
   logic any_stb;
   assign any_stb = mem_oe_o | mem_we_o | io_rd_o | io_wr_o;

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_oe_o, mem_we_o, io_rd_o, io_wr_o}));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !addr_vld_o);

   p_strobe_has_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |-> addr_vld_o);

   p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_stb) |-> $past(addr_vld_o));

   p_hold_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_stb) |-> addr_vld_o);

   p_read_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_oe_o || io_rd_o) |-> !data_oe_o);

   p_write_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o || io_wr_o) |-> data_oe_o);
endmodule

bind card_strobe_seq card_strobe_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_vld_o (addr_vld_o),
   .mem_oe_o   (mem_oe_o),
   .mem_we_o   (mem_we_o),
   .io_rd_o    (io_rd_o),
   .io_wr_o    (io_wr_o),
   .data_oe_o  (data_oe_o),
   .done_o     (done_o)
);

// File: tb/card_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module card_strobe_seq_tb_top;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, wr = 1'b0, io = 1'b0, wen = 1'b0, cwait = 1'b0;
   logic [CW-1:0] scnt = '0, lcnt = '0, hcnt = '0;
   logic addr_vld, moe, mwe, iord, iowr, doe, done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   card_strobe_seq #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .io_i(io),
      .setup_cnt_i(scnt), .strobe_cnt_i(lcnt), .hold_cnt_i(hcnt),
      .wait_en_i(wen), .card_wait_i(cwait),
      .addr_vld_o(addr_vld), .mem_oe_o(moe), .mem_we_o(mwe),
      .io_rd_o(iord), .io_wr_o(iowr), .data_oe_o(doe), .done_o(done)
   );

   function automatic int raise1(int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic check_idle(string tag);
      checks++;
      if ({addr_vld, moe, mwe, iord, iowr, doe, done} !== 7'b0) begin
         errors++;
         $display("FAIL %s idle outputs got %b exp 0000000", tag,
                  {addr_vld, moe, mwe, iord, iowr, doe, done});
      end
   endtask

   // Called at a negedge; returns at a negedge after the idle cycle.
   task automatic run_txn(int s, int l, int h, bit w, bit i, bit we,
                          int j, bit busy_req, string tag);
      int es, lmin, ls, total;
      bit ok;
      logic [3:0] exp_stb, got_stb;
      ok    = 1'b1;
      es    = raise1(s) + ((i && w) ? 1 : 0);
      lmin  = raise1(l) + (we ? 1 : 0);
      ls    = (we && (j + 2 - es > lmin)) ? (j + 2 - es) : lmin;
      total = es + ls + raise1(h);
      scnt = CW'(s); lcnt = CW'(l); hcnt = CW'(h);
      wr = w; io = i; wen = we; cwait = (0 < j);
      req = 1'b1;
      @(negedge clk);
      req = busy_req;
      for (int c = 0; c <= total; c++) begin
         logic exp_av, exp_doe, exp_done;
         bit in_stb;
         in_stb   = (c >= es) && (c < es + ls);
         exp_av   = (c < total);
         exp_doe  = exp_av && w;
         exp_done = (c == total - 1);
         exp_stb  = in_stb ? (4'b0001 << {i, w}) : 4'b0000;
         got_stb  = {iowr, iord, mwe, moe};
         if (ok && addr_vld !== exp_av) begin
            ok = 1'b0;
            $display("FAIL %s R2 cycle %0d addr_vld got %b exp %b", tag, c, addr_vld, exp_av);
         end
         if (ok && got_stb !== exp_stb) begin
            ok = 1'b0;
            $display("FAIL %s R5 cycle %0d strobes got %b exp %b", tag, c, got_stb, exp_stb);
         end
         if (ok && $countones(got_stb) > 1) begin
            ok = 1'b0;
            $display("FAIL %s R12 cycle %0d strobes got %b exp at most one", tag, c, got_stb);
         end
         if (ok && doe !== exp_doe) begin
            ok = 1'b0;
            $display("FAIL %s R8 cycle %0d data_oe got %b exp %b", tag, c, doe, exp_doe);
         end
         if (ok && done !== exp_done) begin
            ok = 1'b0;
            $display("FAIL %s R7 cycle %0d done got %b exp %b", tag, c, done, exp_done);
         end
         cwait = (c + 1 < j);
         req   = 1'b0;
         @(negedge clk);
      end
      checks++;
      if (!ok) errors++;
      cwait = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1 after reset");

      // R3 R4 R5 R6: full sweep of small counts and all kinds, wait off
      for (int s = 0; s < 4; s++)
         for (int l = 0; l < 4; l++)
            for (int h = 0; h < 4; h++)
               for (int k = 0; k < 4; k++)
                  run_txn(s, l, h, k[0], k[1], 1'b0, 0, 1'b0, "R3_R4_R6 sweep");

      // R9: wait enabled, release edge swept
      for (int s = 0; s < 3; s++)
         for (int l = 0; l < 3; l++)
            for (int j = 0; j < 11; j++)
               run_txn(s, l, 1, j[0], j[1], 1'b1, j, 1'b0, "R9 wait sweep");

      // R10: wait line busy but wait disabled
      for (int j = 3; j < 9; j++)
         run_txn(1, 2, 1, 1'b0, j[0], 1'b0, j + 20, 1'b0, "R10 wait ignored");

      // R11: extra request during a running transaction
      for (int k = 0; k < 4; k++)
         run_txn(2, 2, 2, k[0], k[1], 1'b0, 0, 1'b1, "R11 busy request");

      // boundary: largest counts
      run_txn(15, 15, 15, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R4 max counts");
      run_txn(15, 15, 15, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R5 max counts");

      @(negedge clk);
      check_idle("R7 final idle");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule